// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block lets clocked logic read and write an external 32K x 8 static RAM that has no clock of its own. The memory shares one 8-bit bus for read and write data. A requester presents an address, a direction and, for writes, a data byte, and holds a valid flag. The controller takes the request only while it is idle and ready. It then runs the memory strobes through a fixed sequence and reports completion with a single-cycle done pulse. For reads, the byte taken from the bus comes back with that pulse.

Every strobe interval is a whole number of clock cycles. Each one is derived at elaboration from the clock period in nanoseconds and the chosen speed grade (70 ns or 55 ns). The rule is the required time divided by the period, rounded up, and never less than one cycle. The strobe outputs and the bus-driver enable all come from registers, so they cannot glitch.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is high, and on the first cycle after it, chip enable, write enable and output enable (all active low) read 1, the data driver enable reads 0, ready reads 1 and done reads 0. Reset during an access abandons it.
- R2: For a read, chip enable and output enable go low and write enable stays high for exactly max(ceil(tACC/P), ceil(tOE/P)) cycles. With tACC = 70 ns, tOE = 35 ns and P = 4 ns this is 18 cycles. The bus is sampled on the last of those cycles, and the sampled byte appears on the read data output together with done.
- R3: Output enable stays high during every write.
- R4: The write enable low pulse lasts exactly max(ceil(tWP/P), ceil(tAW/P), ceil(tDW/P)) cycles, with tWP = 50, tAW = 60 and tDW = 30 ns. That is 15 cycles at 4 ns. Chip enable and the address are applied one cycle before write enable falls.
- R5: Write data is driven on the bus from one cycle before write enable falls until at least one cycle after it rises.
- R6: Address and write data never change while chip enable and write enable are both low.
- R7: The data driver is never enabled while output enable is low.
- R8: After a read, the data driver stays released for at least ceil(tHZ/P) cycles after output enable returns high (tHZ = 25 ns, giving 7 cycles) before a write drives the bus.
- R9: Chip enable stays low for at least ceil(tWC/P) cycles per write (tWC = 70 ns, giving 18 cycles).
- R10: Done is high for exactly one cycle per accepted request. A request is taken only while ready is high. A valid request, or changed request fields, presented while the controller is busy, has no effect.
- R11: With the fast-grade parameter set, the intervals use tACC = 55, tOE = 25, tWP = 45, tAW = 45, tDW = 25, tWC = 55 and tHZ = 20 ns. At 4 ns this gives a 14-cycle read strobe and a 12-cycle write pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and accepting |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Byte address |
| req_wdata | input | 8 | Byte to write |
| rsp_rdata | output | 8 | Byte read, valid with done |
| rsp_done | output | 1 | One-cycle completion pulse |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | 15 | Memory address lines |
| mem_dq_o | output | 8 | Data toward the memory |
| mem_dq_oe | output | 1 | Enable for the local bus driver |
| mem_dq_i | input | 8 | Data from the shared bus |

## Verification
Each wrong internal state shows up at the ports in a characteristic way:

- **Counter reload off by one.** A read strobe or write pulse comes out one cycle short or long. The strobe-width checks catch this when the strobe ends. A read sampled one cycle early returns the bench memory's garbage byte on the done cycle.
- **Missing turnaround.** The driver comes back within a few cycles of output enable rising, which the gap check detects at that first driven cycle.
- **Stuck or wrong state.** This appears as overlapping strobes or as a missing or double done pulse, visible within one access.

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl #(
  parameter int CLK_PERIOD_NS = 4,
  parameter bit FAST_GRADE    = 1'b0,
  parameter int AW            = 15,
  parameter int DW            = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_done,
  output logic          mem_ce_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_i
);

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int T_ACC = FAST_GRADE ? 55 : 70;
  localparam int T_OE  = FAST_GRADE ? 25 : 35;
  localparam int T_WC  = FAST_GRADE ? 55 : 70;
  localparam int T_WP  = FAST_GRADE ? 45 : 50;
  localparam int T_AW  = FAST_GRADE ? 45 : 60;
  localparam int T_DW  = FAST_GRADE ? 25 : 30;
  localparam int T_HZ  = FAST_GRADE ? 20 : 25;

  localparam int N_RD  = imax(cyc(T_ACC), cyc(T_OE));
  localparam int N_WE  = imax(imax(cyc(T_WP), cyc(T_AW)), cyc(T_DW));
  localparam int N_WH  = imax(1, cyc(T_WC) - N_WE - 1);
  localparam int N_TA  = cyc(T_HZ);
  localparam int N_MAX = imax(imax(N_RD, N_WE), imax(N_WH, N_TA));
  localparam int CW    = $clog2(N_MAX + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_TURN, S_WSET, S_WLOW, S_WEND, S_READ
  } st_t;

  st_t           st, nst;
  logic [CW-1:0] cnt, ld;
  logic          last, after_rd;

  assign last      = (cnt == '0);
  assign req_ready = (st == S_IDLE);

  always_comb begin
    nst = st;
    case (st)
      S_IDLE: if (req_valid) nst = req_write ? (after_rd ? S_TURN : S_WSET) : S_READ;
      S_TURN: if (last) nst = S_WSET;
      S_WSET: nst = S_WLOW;
      S_WLOW: if (last) nst = S_WEND;
      S_WEND: if (last) nst = S_IDLE;
      S_READ: if (last) nst = S_IDLE;
      default: nst = S_IDLE;
    endcase
  end

  always_comb begin
    case (nst)
      S_TURN:  ld = CW'(N_TA - 1);
      S_WLOW:  ld = CW'(N_WE - 1);
      S_WEND:  ld = CW'(N_WH - 1);
      S_READ:  ld = CW'(N_RD - 1);
      default: ld = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      cnt       <= '0;
      after_rd  <= 1'b0;
      mem_ce_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
      mem_addr  <= '0;
      mem_dq_o  <= '0;
      rsp_rdata <= '0;
      rsp_done  <= 1'b0;
    end else begin
      st  <= nst;
      cnt <= (nst != st) ? ld : (last ? cnt : cnt - 1'b1);
      if (st == S_IDLE && req_valid) begin
        mem_addr <= req_addr;
        mem_dq_o <= req_wdata;
      end
      if (st == S_READ && last) begin
        rsp_rdata <= mem_dq_i;
        after_rd  <= 1'b1;
      end else if (nst == S_WSET) begin
        after_rd  <= 1'b0;
      end
      rsp_done  <= (st == S_READ || st == S_WEND) && last;
      mem_ce_n  <= !(nst inside {S_WSET, S_WLOW, S_WEND, S_READ});
      mem_we_n  <= (nst != S_WLOW);
      mem_oe_n  <= (nst != S_READ);
      mem_dq_oe <= (nst inside {S_WSET, S_WLOW, S_WEND});
    end
  end

  logic [CW:0] we_run, oe_gap;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_run <= '0;
      oe_gap <= (CW+1)'(N_TA);
    end else begin
      we_run <= mem_we_n ? '0 : we_run + 1'b1;
      if (!mem_oe_n)               oe_gap <= '0;
      else if (oe_gap < (CW+1)'(N_TA)) oe_gap <= oe_gap + 1'b1;
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_done));

  p_read_strobes_r2: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (!mem_ce_n && mem_we_n));

  p_oe_high_write_r3: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> mem_oe_n);

  p_we_width_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (we_run == (CW+1)'(N_WE)));

  p_data_at_rise_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (mem_dq_oe && !mem_ce_n));

  p_addr_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce_n && !mem_we_n) |=>
      (mem_ce_n || mem_we_n || ($stable(mem_addr) && $stable(mem_dq_o))));

  p_no_contention_r7: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> !mem_dq_oe);

  p_turn_gap_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_dq_oe) |-> (oe_gap >= (CW+1)'(N_TA)));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

  p_accept_r10: assert property (@(posedge clk) disable iff (rst)
    (req_ready && req_valid) |=> !req_ready);

endmodule

// File: tb/sim_sram_async_ctrl.sv
module sim_sram_async_ctrl;
  localparam int P = 4;

  function automatic int cyc(input int ns);
    int c;
    c = (ns + P - 1) / P;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_RD = imax(cyc(70), cyc(35));
  localparam int E_WE = imax(imax(cyc(50), cyc(60)), cyc(30));
  localparam int E_WC = cyc(70);
  localparam int E_TA = cyc(25);
  localparam int F_RD = imax(cyc(55), cyc(25));
  localparam int F_WE = imax(imax(cyc(45), cyc(45)), cyc(25));

  logic clk = 1'b0, rst = 1'b1;
  always #2 clk = ~clk;

  logic valid = 1'b0, wr = 1'b0;
  logic [14:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, dqo, dqi;
  logic done, ready, ce_n, we_n, oe_n, dqoe;
  logic [14:0] maddr;

  sram_async_ctrl #(.CLK_PERIOD_NS(P), .FAST_GRADE(1'b0)) u0 (
    .clk(clk), .rst(rst), .req_valid(valid), .req_ready(ready), .req_write(wr),
    .req_addr(addr), .req_wdata(wdata), .rsp_rdata(rdata), .rsp_done(done),
    .mem_ce_n(ce_n), .mem_we_n(we_n), .mem_oe_n(oe_n), .mem_addr(maddr),
    .mem_dq_o(dqo), .mem_dq_oe(dqoe), .mem_dq_i(dqi));

  logic f_valid = 1'b0, f_wr = 1'b0;
  logic [7:0] f_rdata, f_dqo;
  logic f_done, f_ready, f_ce_n, f_we_n, f_oe_n, f_dqoe;
  logic [14:0] f_maddr;

  sram_async_ctrl #(.CLK_PERIOD_NS(P), .FAST_GRADE(1'b1)) u1 (
    .clk(clk), .rst(rst), .req_valid(f_valid), .req_ready(f_ready), .req_write(f_wr),
    .req_addr(15'h0042), .req_wdata(8'h66), .rsp_rdata(f_rdata), .rsp_done(f_done),
    .mem_ce_n(f_ce_n), .mem_we_n(f_we_n), .mem_oe_n(f_oe_n), .mem_addr(f_maddr),
    .mem_dq_o(f_dqo), .mem_dq_oe(f_dqoe), .mem_dq_i(8'h3C));

  logic [7:0] mem [int];
  int age = 0, gap = 1000, min_gap = 1000;
  int ce_run = 0, last_ce = 0, we_run = 0, last_we = 0, done_cnt = 0;
  int f_ce_run = 0, f_last_ce = 0, f_we_run = 0, f_last_we = 0;
  int v_oe = 0, v_drv = 0, v_addr = 0, v_data = 0;
  logic p_we = 1'b1, p_ce = 1'b1, p_dqoe = 1'b0;
  logic [14:0] p_addr = '0;
  logic [7:0] p_dqo = '0;

  always @(negedge clk) begin
    if (!rst) begin
      if (!ce_n && !oe_n && we_n) age = age + 1; else age = 0;
      if (!ce_n && !oe_n && we_n && age * P >= 70)
        dqi = mem.exists(int'(maddr)) ? mem[int'(maddr)] : 8'h00;
      else
        dqi = 8'hEE;
      if (!we_n && !oe_n) v_oe++;
      if (dqoe && !oe_n) v_drv++;
      if (!ce_n && !we_n && !p_ce && !p_we && (maddr != p_addr || dqo != p_dqo)) v_addr++;
      if (!p_we && we_n && !ce_n) begin
        if (!dqoe) v_data++;
        mem[int'(maddr)] = dqo;
      end
      if (!oe_n) gap = 0; else gap++;
      if (dqoe && !p_dqoe && gap < min_gap) min_gap = gap;
      if (!ce_n) ce_run++; else if (ce_run > 0) begin last_ce = ce_run; ce_run = 0; end
      if (!we_n) we_run++; else if (we_run > 0) begin last_we = we_run; we_run = 0; end
      if (!f_ce_n) f_ce_run++; else if (f_ce_run > 0) begin f_last_ce = f_ce_run; f_ce_run = 0; end
      if (!f_we_n) f_we_run++; else if (f_we_run > 0) begin f_last_we = f_we_run; f_we_run = 0; end
      if (done) done_cnt++;
    end else begin
      age = 0; ce_run = 0; we_run = 0; dqi = 8'hEE;
    end
    p_we = we_n; p_ce = ce_n; p_addr = maddr; p_dqo = dqo; p_dqoe = dqoe;
  end

  int nchk = 0, nerr = 0;
  bit reported = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
    end
    $finish;
  endtask

  task automatic op(input bit w, input logic [14:0] a, input logic [7:0] d,
                    output logic [7:0] r);
    int n;
    @(negedge clk);
    valid = 1'b1; wr = w; addr = a; wdata = d;
    @(negedge clk);
    valid = 1'b0;
    n = 0;
    while (!done && n < 200) begin @(negedge clk); n++; end
    r = rdata;
    @(negedge clk);
    chk(!done, "R10 done one cycle", int'(done), 0);
  endtask

  localparam logic [23:0] VEC [8] = '{
    {1'b1, 15'h0000, 8'h11}, {1'b1, 15'h7FFF, 8'hA5},
    {1'b0, 15'h0000, 8'h11}, {1'b0, 15'h7FFF, 8'hA5},
    {1'b1, 15'h2AAA, 8'h5C}, {1'b1, 15'h5555, 8'h3B},
    {1'b0, 15'h2AAA, 8'h5C}, {1'b0, 15'h5555, 8'h3B}
  };

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [7:0] r;
    int dc;
    repeat (3) @(negedge clk);
    chk(ce_n && we_n && oe_n, "R1 strobes in reset", {ce_n, we_n, oe_n}, 7);
    chk(!dqoe && ready && !done, "R1 idle in reset", {dqoe, ready, done}, 2);
    rst = 1'b0;
    @(negedge clk);
    chk(ce_n && we_n && oe_n && !dqoe, "R1 after reset", {ce_n, we_n, oe_n, dqoe}, 14);

    for (int i = 0; i < 8; i++) begin
      op(VEC[i][23], VEC[i][22:8], VEC[i][7:0], r);
      if (VEC[i][23]) begin
        chk(last_we == E_WE, "R4 write pulse", last_we, E_WE);
        chk(last_ce >= E_WC, "R9 write cycle", last_ce, E_WC);
      end else begin
        chk(r == VEC[i][7:0], "R2 read data", r, VEC[i][7:0]);
        chk(last_ce == E_RD, "R2 read strobe", last_ce, E_RD);
      end
    end

    dc = done_cnt;
    @(negedge clk);
    valid = 1'b1; wr = 1'b1; addr = 15'h1234; wdata = 8'h77;
    @(negedge clk);
    addr = 15'h4321; wdata = 8'h99;
    repeat (6) @(negedge clk);
    valid = 1'b0;
    repeat (40) @(negedge clk);
    chk(done_cnt - dc == 1, "R10 one done per request", done_cnt - dc, 1);
    op(1'b0, 15'h4321, 8'h00, r);
    chk(r == 8'h00, "R10 busy request ignored", r, 0);
    op(1'b0, 15'h1234, 8'h00, r);
    chk(r == 8'h77, "R10 latched request", r, 8'h77);

    @(negedge clk);
    valid = 1'b1; wr = 1'b1; addr = 15'h0100; wdata = 8'h44;
    @(negedge clk);
    valid = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(ce_n && we_n && oe_n && !dqoe && ready, "R1 reset mid write",
        {ce_n, we_n, oe_n, dqoe, ready}, 29);
    rst = 1'b0;
    op(1'b1, 15'h0200, 8'h21, r);
    op(1'b0, 15'h0200, 8'h00, r);
    chk(r == 8'h21, "R1 resumes after reset", r, 8'h21);

    chk(v_oe == 0, "R3 output enable during write", v_oe, 0);
    chk(v_data == 0, "R5 data at write enable rise", v_data, 0);
    chk(v_addr == 0, "R6 address stable in write", v_addr, 0);
    chk(v_drv == 0, "R7 bus contention", v_drv, 0);
    chk(min_gap - 1 >= E_TA, "R8 turnaround gap", min_gap - 1, E_TA);

    @(negedge clk); f_valid = 1'b1; f_wr = 1'b1;
    @(negedge clk); f_valid = 1'b0;
    repeat (30) @(negedge clk);
    chk(f_last_we == F_WE, "R11 fast write pulse", f_last_we, F_WE);
    f_valid = 1'b1; f_wr = 1'b0;
    @(negedge clk); f_valid = 1'b0;
    for (int k = 0; k < 40 && !f_done; k++) @(negedge clk);
    chk(f_rdata == 8'h3C, "R11 fast read data", f_rdata, 8'h3C);
    repeat (2) @(negedge clk);
    chk(f_last_ce == F_RD, "R11 fast read strobe", f_last_ce, F_RD);

    report();
  end
endmodule